// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Controller

This block turns two ordinary push-buttons into a guarded source of system reset. A brief press of either button is left to the rest of the system, for example as an interrupt. Only when both buttons are held down together, without a break, for a long setup interval does the block assert its reset output. The setup interval, the reset pulse length and the test-mode intervals are all parameters counted in clock cycles.

The output has two duration modes, chosen by a parameter. In fixed-pulse mode the reset lasts exactly one recovery interval, whatever the buttons do. In level mode it lasts for as long as both buttons stay held. The output polarity is a second parameter. A test mode, entered by holding a high-voltage detect flag for an initial interval, gives a reset-shaped feedback on the output and then replaces the long setup interval with a short one. Only a power-on reset leaves test mode. While an undervoltage flag is set, the buttons are ignored and the output is held deasserted.

All four inputs pass through a two-flop synchronizer, so every response below counts those two cycles.

Top module: `dbr_ctrl`

## Requirements
- R1: With both buttons held (low) from a point before clock edge 0, the output is still deasserted after edge SETUP+1 and is asserted after edge SETUP+2, where SETUP is LONG_CYC in normal mode.
- R2: Releasing either button before the setup interval completes cancels the count. The next joint press counts again from zero. Holding only one button never asserts reset.
- R3: In fixed-pulse mode (FIXED_PULSE=1) the reset stays asserted for exactly REC_CYC cycles and is not shortened by releasing the buttons.
- R4: In fixed-pulse mode, after the pulse ends, no new count starts until neither button is pressed. While the buttons stay held, the output stays deasserted.
- R5: In level mode (FIXED_PULSE=0) the reset stays asserted while both buttons are held. It is deasserted after the third clock edge that follows the release of either button.
- R6: With ACTIVE_HIGH=0 the asserted output level is 0, and with ACTIVE_HIGH=1 it is 1. After power-on reset the output is at the deasserted level.
- R7: Holding the high-voltage flag from before edge 0 for INIT_CYC cycles enters test mode, with feedback asserted after edge INIT_CYC+2. Dropping the flag earlier enters nothing and asserts nothing.
- R8: The test-entry feedback is a REC_CYC-cycle pulse in fixed-pulse mode. In level mode it is held for as long as the flag stays set, and it ends after the third edge that follows the flag's fall.
- R9: In test mode every joint press uses SHORT_CYC in place of LONG_CYC as its setup interval, with the same two-cycle synchronizer latency as R1.
- R10: Test mode stays active until power-on reset. Raising the flag again has no effect, and after power-on reset the setup interval is LONG_CYC again.
- R11: While the undervoltage flag is set, the buttons are ignored and the output is deasserted within three edges, even during a pulse. The sequence in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| btn0_n | input | 1 | First push-button, active low |
| btn1_n | input | 1 | Second push-button, active low |
| hv_det | input | 1 | High-voltage detect flag on the first button line, active high |
| uv_det | input | 1 | Supply undervoltage flag, active high |
| rst_out | output | 1 | System reset output, polarity set by ACTIVE_HIGH |

## Verification
The bench checks the setup count at the exact edge on each side of its end, so an off-by-one counter, or one that forgets the two synchronizer stages, would assert one cycle early or late. It breaks a joint press near the end of the count and presses again. A design that kept its count would then fire too early. It holds the buttons after a fixed pulse, which a design without the release guard would answer with a second reset. It also releases the buttons in the middle of a pulse, which a design that tied the pulse to the buttons would cut short. For test mode it checks an aborted entry, the sticky short interval after the flag is raised again, and the return to the long interval only after power-on reset.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_FIXED,
    ST_LEVEL,
    ST_REARM,
    ST_TINIT,
    ST_TFB
  } dbr_state_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // counter width able to hold every interval limit
  function automatic int cnt_width(input int a, input int b, input int c, input int d);
    return $clog2(max4(a, b, c, d) + 1);
  endfunction

  // setup interval in force for a joint press
  function automatic int pick_setup(input bit test_on, input int long_c, input int short_c);
    return test_on ? short_c : long_c;
  endfunction

  // pin level for an internal active flag
  function automatic logic drive_level(input logic act, input bit active_high);
    return active_high ? act : ~act;
  endfunction

endpackage

// File: rtl/dbr_sync.sv
module dbr_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dbr_timer.sv
module dbr_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          start,
  input  logic          run,
  input  logic [CW-1:0] lim,
  output logic          hit
);
  logic [CW-1:0] cnt;

  assign hit = run && (cnt == lim - CW'(1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cnt <= '0;
    else if (start)      cnt <= '0;
    else if (run && !hit) cnt <= cnt + CW'(1);
  end

  // R1: a running count never passes its limit
  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!por_n)
    run |-> (cnt < lim));
endmodule

// File: rtl/dbr_seq.sv
module dbr_seq
  import dbr_pkg::*;
#(
  parameter int CW          = 8,
  parameter int LONG_CYC    = 100,
  parameter int SHORT_CYC   = 10,
  parameter int INIT_CYC    = 20,
  parameter int REC_CYC     = 10,
  parameter bit FIXED_PULSE = 1'b1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          press0,
  input  logic          press1,
  input  logic          hv,
  input  logic          uv,
  input  logic          hit,
  output logic          start,
  output logic          run,
  output logic [CW-1:0] lim,
  output logic          act,
  output logic          test_on
);
  localparam logic [CW-1:0] LIM_INIT = CW'(INIT_CYC);
  localparam logic [CW-1:0] LIM_REC  = CW'(REC_CYC);

  dbr_state_t    st, nxt;
  logic          both, anyp, enter_test;
  logic [CW-1:0] lim_setup;

  assign both      = press0 & press1;
  assign anyp      = press0 | press1;
  assign lim_setup = CW'(pick_setup(test_on, LONG_CYC, SHORT_CYC));

  always_comb begin
    nxt = st;
    run = 1'b0;
    lim = '0;
    case (st)
      ST_IDLE: begin
        if (hv && !test_on) nxt = ST_TINIT;
        else if (both)      nxt = ST_ARM;
      end
      ST_ARM: begin
        lim = lim_setup;
        run = both;
        if (!both)   nxt = ST_IDLE;
        else if (hit) nxt = FIXED_PULSE ? ST_FIXED : ST_LEVEL;
      end
      ST_FIXED: begin
        lim = LIM_REC;
        run = 1'b1;
        if (hit) nxt = ST_REARM;
      end
      ST_LEVEL: begin
        if (!both) nxt = ST_IDLE;
      end
      ST_REARM: begin
        if (!anyp) nxt = ST_IDLE;
      end
      ST_TINIT: begin
        lim = LIM_INIT;
        run = hv;
        if (!hv)      nxt = ST_IDLE;
        else if (hit) nxt = FIXED_PULSE ? ST_FIXED : ST_TFB;
      end
      ST_TFB: begin
        if (!hv) nxt = ST_REARM;
      end
      default: nxt = ST_IDLE;
    endcase
    if (uv) nxt = ST_IDLE;
  end

  assign start = (nxt != st) &&
                 (nxt == ST_ARM || nxt == ST_FIXED || nxt == ST_TINIT);

  assign enter_test = (st == ST_TINIT) && hv && hit && !uv;

  assign act = (st == ST_FIXED || st == ST_LEVEL || st == ST_TFB) && !uv;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st      <= ST_IDLE;
      test_on <= 1'b0;
    end else begin
      st      <= nxt;
      test_on <= test_on | enter_test;
    end
  end

  // R2: a broken joint press never leads to reset
  a_r2_break_no_reset: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_ARM && !both) |=> !act);

  // R4: held buttons after a fixed pulse keep the output quiet
  a_r4_rearm_blocks: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_REARM && anyp) |=> !act);

  // R7: an aborted entry leaves normal mode in place
  a_r7_abort_no_test: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_TINIT && !hv && !test_on) |=> !test_on);

  // R10: test mode is sticky
  a_r10_test_sticky: assert property (@(posedge clk) disable iff (!por_n)
    test_on |=> test_on);

  // R11: undervoltage abandons any sequence
  a_r11_uv_idles: assert property (@(posedge clk) disable iff (!por_n)
    uv |=> (st == ST_IDLE && !act));
endmodule

// File: rtl/dbr_ctrl.sv
module dbr_ctrl
  import dbr_pkg::*;
#(
  parameter int LONG_CYC    = 50_000_000,
  parameter int SHORT_CYC   = 1_050_000,
  parameter int INIT_CYC    = 2_100_000,
  parameter int REC_CYC     = 10_000_000,
  parameter bit FIXED_PULSE = 1'b1,
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic btn0_n,
  input  logic btn1_n,
  input  logic hv_det,
  input  logic uv_det,
  output logic rst_out
);
  localparam int CW = cnt_width(LONG_CYC, SHORT_CYC, INIT_CYC, REC_CYC);

  logic [3:0]    raw, syn;
  logic          press0, press1, hv_s, uv_s;
  logic          t_start, t_run, t_hit, act, test_on;
  logic [CW-1:0] t_lim;

  assign raw = {uv_det, hv_det, ~btn1_n, ~btn0_n};

  dbr_sync #(.W(4)) sync_i (
    .clk   (clk),
    .por_n (por_n),
    .d     (raw),
    .q     (syn)
  );

  assign press0 = syn[0];
  assign press1 = syn[1];
  assign hv_s   = syn[2];
  assign uv_s   = syn[3];

  dbr_timer #(.CW(CW)) timer_i (
    .clk   (clk),
    .por_n (por_n),
    .start (t_start),
    .run   (t_run),
    .lim   (t_lim),
    .hit   (t_hit)
  );

  dbr_seq #(
    .CW          (CW),
    .LONG_CYC    (LONG_CYC),
    .SHORT_CYC   (SHORT_CYC),
    .INIT_CYC    (INIT_CYC),
    .REC_CYC     (REC_CYC),
    .FIXED_PULSE (FIXED_PULSE)
  ) seq_i (
    .clk     (clk),
    .por_n   (por_n),
    .press0  (press0),
    .press1  (press1),
    .hv      (hv_s),
    .uv      (uv_s),
    .hit     (t_hit),
    .start   (t_start),
    .run     (t_run),
    .lim     (t_lim),
    .act     (act),
    .test_on (test_on)
  );

  assign rst_out = drive_level(act, ACTIVE_HIGH);

  // R11: synchronized undervoltage keeps the pin deasserted
  a_r11_uv_pin_quiet: assert property (@(posedge clk) disable iff (!por_n)
    uv_s |-> (rst_out == drive_level(1'b0, ACTIVE_HIGH)));
endmodule

// File: tb/dbr_ctrl_tb_top.sv
module dbr_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int LONG  = 40;
  localparam int SHORT = 10;
  localparam int INIT  = 16;
  localparam int REC   = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic b0n = 1'b1, b1n = 1'b1, hv = 1'b0, uv = 1'b0;
  logic rst_f, rst_l;
  int   n_chk = 0, n_bad = 0;
  bit   fin = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  // fixed pulse, active low
  dbr_ctrl #(.LONG_CYC(LONG), .SHORT_CYC(SHORT), .INIT_CYC(INIT), .REC_CYC(REC),
             .FIXED_PULSE(1'b1), .ACTIVE_HIGH(1'b0)) dut_i (
    .clk(clk), .por_n(por_n), .btn0_n(b0n), .btn1_n(b1n),
    .hv_det(hv), .uv_det(uv), .rst_out(rst_f));

  // level mode, active high
  dbr_ctrl #(.LONG_CYC(LONG), .SHORT_CYC(SHORT), .INIT_CYC(INIT), .REC_CYC(REC),
             .FIXED_PULSE(1'b0), .ACTIVE_HIGH(1'b1)) dut_lvl_i (
    .clk(clk), .por_n(por_n), .btn0_n(b0n), .btn1_n(b1n),
    .hv_det(hv), .uv_det(uv), .rst_out(rst_l));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic a, input logic e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, a, e);
    end
  endtask

  // asserted views of the two outputs
  function automatic logic on_f();
    return rst_f === 1'b0;
  endfunction
  function automatic logic on_l();
    return rst_l === 1'b1;
  endfunction

  task automatic t_reset_state();
    chk("R6 fixed pin idle after por", rst_f, 1'b1);
    chk("R6 level pin idle after por", rst_l, 1'b0);
  endtask

  task automatic t_long_press();
    b0n = 0; b1n = 0;
    step(LONG + 2);
    chk("R1 fixed not yet at SETUP+1", on_f(), 1'b0);
    chk("R1 level not yet at SETUP+1", on_l(), 1'b0);
    step(1);
    chk("R1 R6 fixed pin low at SETUP+2", rst_f, 1'b0);
    chk("R1 R6 level pin high at SETUP+2", rst_l, 1'b1);
    step(REC - 1);
    chk("R3 fixed last pulse cycle", on_f(), 1'b1);
    step(1);
    chk("R3 fixed ends after REC", on_f(), 1'b0);
    chk("R5 level held while pressed", on_l(), 1'b1);
    step(3 * LONG);
    chk("R4 fixed no second reset while held", on_f(), 1'b0);
    chk("R5 level still held", on_l(), 1'b1);
    b1n = 1;
    step(2);
    chk("R5 level before release reaches it", on_l(), 1'b1);
    step(1);
    chk("R5 level drops on third edge", on_l(), 1'b0);
    b0n = 1;
    step(4);
  endtask

  task automatic t_cancel();
    b0n = 0;
    step(2 * LONG);
    chk("R2 fixed single button no reset", on_f(), 1'b0);
    chk("R2 level single button no reset", on_l(), 1'b0);
    b1n = 0;
    step(LONG);
    b1n = 1;
    step(3);
    b1n = 0;
    step(LONG + 2);
    chk("R2 fixed count restarted", on_f(), 1'b0);
    chk("R2 level count restarted", on_l(), 1'b0);
    step(1);
    chk("R2 fixed asserts after full recount", on_f(), 1'b1);
    b0n = 1; b1n = 1;
    step(REC - 1);
    chk("R3 fixed pulse survives release", on_f(), 1'b1);
    chk("R5 level dropped on release", on_l(), 1'b0);
    step(1);
    chk("R3 fixed ends on time after release", on_f(), 1'b0);
    step(4);
  endtask

  task automatic t_uv();
    uv = 1; b0n = 0; b1n = 0;
    step(2 * LONG);
    chk("R11 fixed buttons ignored under uv", on_f(), 1'b0);
    chk("R11 level buttons ignored under uv", on_l(), 1'b0);
    b0n = 1; b1n = 1;
    step(3);
    uv = 0;
    step(5);
    b0n = 0; b1n = 0;
    step(LONG + 3);
    chk("R11 fixed asserts once uv gone", on_f(), 1'b1);
    uv = 1;
    step(3);
    chk("R11 fixed pulse cut by uv", on_f(), 1'b0);
    chk("R11 level cut by uv", on_l(), 1'b0);
    b0n = 1; b1n = 1;
    step(5);
    uv = 0;
    step(5);
    chk("R11 fixed stays idle after uv", on_f(), 1'b0);
  endtask

  task automatic t_test_abort();
    hv = 1;
    step(INIT - 2);
    hv = 0;
    step(INIT + 10);
    chk("R7 fixed no feedback on short flag", on_f(), 1'b0);
    chk("R7 level no feedback on short flag", on_l(), 1'b0);
    b0n = 0; b1n = 0;
    step(SHORT + 3);
    chk("R7 fixed still long interval", on_f(), 1'b0);
    b0n = 1; b1n = 1;
    step(5);
  endtask

  task automatic t_test_enter();
    hv = 1;
    step(INIT + 2);
    chk("R7 fixed no feedback at INIT+1", on_f(), 1'b0);
    chk("R7 level no feedback at INIT+1", on_l(), 1'b0);
    step(1);
    chk("R7 fixed feedback at INIT+2", on_f(), 1'b1);
    chk("R7 level feedback at INIT+2", on_l(), 1'b1);
    step(REC - 1);
    chk("R8 fixed feedback last cycle", on_f(), 1'b1);
    step(1);
    chk("R8 fixed feedback length REC", on_f(), 1'b0);
    step(10);
    chk("R8 level feedback while flag set", on_l(), 1'b1);
    chk("R10 fixed flag ignored in test mode", on_f(), 1'b0);
    hv = 0;
    step(2);
    chk("R8 level feedback before flag fall seen", on_l(), 1'b1);
    step(1);
    chk("R8 level feedback ends third edge", on_l(), 1'b0);
    step(3);
    b0n = 0; b1n = 0;
    step(SHORT + 2);
    chk("R9 fixed not yet at SHORT+1", on_f(), 1'b0);
    chk("R9 level not yet at SHORT+1", on_l(), 1'b0);
    step(1);
    chk("R9 fixed short setup", on_f(), 1'b1);
    chk("R9 level short setup", on_l(), 1'b1);
    b0n = 1; b1n = 1;
    step(REC + 5);
    hv = 1;
    step(INIT + 10);
    chk("R10 fixed no re-entry", on_f(), 1'b0);
    chk("R10 level no re-entry", on_l(), 1'b0);
    hv = 0;
    step(4);
    b0n = 0; b1n = 0;
    step(SHORT + 3);
    chk("R10 fixed short interval kept", on_f(), 1'b1);
    b0n = 1; b1n = 1;
    step(REC + 5);
  endtask

  task automatic t_por_exit();
    por_n = 0;
    step(2);
    por_n = 1;
    step(2);
    b0n = 0; b1n = 0;
    step(SHORT + 3);
    chk("R10 fixed long again after por", on_f(), 1'b0);
    chk("R10 level long again after por", on_l(), 1'b0);
    step(LONG - SHORT);
    chk("R10 fixed asserts at LONG after por", on_f(), 1'b1);
    chk("R10 level asserts at LONG after por", on_l(), 1'b1);
    b0n = 1; b1n = 1;
    step(REC + 5);
  endtask

  initial begin
    step(3);
    por_n = 1;
    step(2);
    t_reset_state();
    t_long_press();
    t_cancel();
    t_uv();
    t_test_abort();
    t_test_enter();
    t_por_exit();
    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule